// File: doc/BRIEF.md
# Interrupt Masking and Routing Unit

This block is the front end of an interrupt controller. It gathers one request line per source from the hardware, merges each line with a request bit that software can set, gates every source with its own enable bit, and steers each enabled source to one of two processor request outputs: a normal interrupt line (IRQ) or a fast interrupt line (FIQ). Priority and vector selection sit downstream and are not part of this block.

Software controls the unit through a small register file on a simple single-cycle bus. Enables and software requests use separate set and clear locations, so one source can be changed without a read-modify-write. Three read-only views show the merged requests before masking and the masked requests of each route. A protection bit, which only privileged accesses can change, stops user-mode accesses: a blocked write changes nothing and a blocked read returns zero.

Hardware lines are active-high and level-sensitive. The two outputs follow the registers and the request lines combinationally. Read data is registered and appears on the clock edge that accepts the read.

Top module: `intr_route_unit`

## Requirements
- R1: After reset every enable, route, software-request and protection bit is 0, so `irq_o` and `fiq_o` are 0 and every readable register returns 0.
- R2: The raw view at offset 0x08 returns, per source, the hardware line ORed with the software-request bit, whatever the enable and route bits are.
- R3: The IRQ view at offset 0x00 returns, per source, raw AND enable AND NOT route; `irq_o` is 1 exactly when any bit of that view is 1.
- R4: The FIQ view at offset 0x04 returns, per source, raw AND enable AND route; `fiq_o` is 1 exactly when any bit of that view is 1.
- R5: The route register at offset 0x0C is written whole and reads back as written; route bit n = 1 sends source n to FIQ, 0 sends it to IRQ.
- R6: A write to offset 0x10 sets every enable bit whose data bit is 1 and leaves the others; a write to offset 0x14 clears every enable bit whose data bit is 1; reading 0x10 returns the enable bits.
- R7: A write to offset 0x18 sets every software-request bit whose data bit is 1; a write to offset 0x1C clears every such bit whose data bit is 1; reading 0x18 returns the software-request bits.
- R8: The protection register at offset 0x20 holds one bit in data bit 0; it changes only on a write with `bus_priv` = 1 and reads back with all other bits 0.
- R9: While the protection bit is 1, an access with `bus_priv` = 0 is blocked: a write to any offset changes no state and a read returns 0.
- R10: `bus_rdata` changes only on a clock edge that accepts a read, returns the value from before a write accepted on the same edge, returns 0 for an unmapped offset, and writes to read-only or unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hw_req | input | NUM_SRC | Hardware request lines, one per source, active high, level |
| bus_wr_en | input | 1 | Write strobe for the addressed register |
| bus_rd_en | input | 1 | Read strobe for the addressed register |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_priv | input | 1 | 1 when the access comes from a privileged mode |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
Two functions can land on the same edge: a register write and a read of the same offset, and a software-request clear while the hardware line of that source is still high. The bench issues a set-enable write and a read of the enable register in one cycle and expects the old enable value, then reads again and expects the new one. It clears a software request whose hardware line is asserted and expects the raw bit and the masked view to stay at 1, and the request output to stay high.

// File: rtl/intr_route_pkg.sv
// Shared definitions for the interrupt masking and routing unit.
// Assumes byte offsets of at most 8 significant bits.
package intr_route_pkg;

    localparam logic [7:0] OFF_IRQ_VIEW = 8'h00;
    localparam logic [7:0] OFF_FIQ_VIEW = 8'h04;
    localparam logic [7:0] OFF_RAW_VIEW = 8'h08;
    localparam logic [7:0] OFF_ROUTE    = 8'h0C;
    localparam logic [7:0] OFF_EN_SET   = 8'h10;
    localparam logic [7:0] OFF_EN_CLR   = 8'h14;
    localparam logic [7:0] OFF_SW_SET   = 8'h18;
    localparam logic [7:0] OFF_SW_CLR   = 8'h1C;
    localparam logic [7:0] OFF_GUARD    = 8'h20;

    typedef enum logic [3:0] {
        SEL_IRQ_VIEW,
        SEL_FIQ_VIEW,
        SEL_RAW_VIEW,
        SEL_ROUTE,
        SEL_EN_SET,
        SEL_EN_CLR,
        SEL_SW_SET,
        SEL_SW_CLR,
        SEL_GUARD,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic route;
        logic en_set;
        logic en_clr;
        logic sw_set;
        logic sw_clr;
        logic guard;
    } wr_strobe_t;

    // Map a byte offset onto a register selector.
    function automatic reg_sel_e decode_offset(input logic [7:0] off);
        reg_sel_e s;
        case (off)
            OFF_IRQ_VIEW: s = SEL_IRQ_VIEW;
            OFF_FIQ_VIEW: s = SEL_FIQ_VIEW;
            OFF_RAW_VIEW: s = SEL_RAW_VIEW;
            OFF_ROUTE:    s = SEL_ROUTE;
            OFF_EN_SET:   s = SEL_EN_SET;
            OFF_EN_CLR:   s = SEL_EN_CLR;
            OFF_SW_SET:   s = SEL_SW_SET;
            OFF_SW_CLR:   s = SEL_SW_CLR;
            OFF_GUARD:    s = SEL_GUARD;
            default:      s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/intr_bus_gate.sv
// Access qualification and register decode.
// Applies the user-mode guard to every access and turns an accepted write
// into one strobe per writable register. Purely combinational.
// Assumes at most one register is addressed per cycle.
module intr_bus_gate
    import intr_route_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              priv,
    input  logic              guard_q,
    output wr_strobe_t        wr_stb,
    output logic              rd_ok,
    output reg_sel_e          rd_sel
);

    localparam int OFF_BITS = 8;

    logic     blocked;
    logic     wr_ok;
    logic     high_zero;
    reg_sel_e sel;

    // Decode the offset; address bits above the offset field must be zero.
    always_comb begin
        high_zero = ((addr >> OFF_BITS) == '0);
        sel       = high_zero ? decode_offset(OFF_BITS'(addr)) : SEL_NONE;
    end

    // Apply the guard: user accesses are refused while it is set.
    always_comb begin
        blocked = guard_q & ~priv;
        wr_ok   = wr_en & ~blocked;
        rd_ok   = rd_en & ~blocked;
        rd_sel  = sel;
    end

    // Produce one write strobe per writable register.
    always_comb begin
        wr_stb        = '0;
        wr_stb.route  = wr_ok & (sel == SEL_ROUTE);
        wr_stb.en_set = wr_ok & (sel == SEL_EN_SET);
        wr_stb.en_clr = wr_ok & (sel == SEL_EN_CLR);
        wr_stb.sw_set = wr_ok & (sel == SEL_SW_SET);
        wr_stb.sw_clr = wr_ok & (sel == SEL_SW_CLR);
        wr_stb.guard  = wr_ok & priv & (sel == SEL_GUARD);
    end

endmodule

// File: rtl/intr_src_cell.sv
// State and routing for a single interrupt source.
// Holds the enable, route and software-request bits of one source and forms
// its raw, IRQ-masked and FIQ-masked request. Assumes the set and clear
// strobes are never active together (one register per cycle).
module intr_src_cell
    import intr_route_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hw_line,
    input  logic       wbit,
    input  wr_strobe_t wr_stb,
    output logic       en_q,
    output logic       route_q,
    output logic       sw_q,
    output logic       raw,
    output logic       irq_hit,
    output logic       fiq_hit
);

    // Enable bit: set by a 1 on the set location, cleared by a 1 on the clear location.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (wr_stb.en_set && wbit) begin
            en_q <= 1'b1;
        end else if (wr_stb.en_clr && wbit) begin
            en_q <= 1'b0;
        end
    end

    // Route bit: plain write, 1 steers the source to the fast output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= 1'b0;
        end else if (wr_stb.route) begin
            route_q <= wbit;
        end
    end

    // Software request bit: set and clear locations as for the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q <= 1'b0;
        end else if (wr_stb.sw_set && wbit) begin
            sw_q <= 1'b1;
        end else if (wr_stb.sw_clr && wbit) begin
            sw_q <= 1'b0;
        end
    end

    // Merge the two request origins, then mask and steer.
    always_comb begin
        raw     = hw_line | sw_q;
        irq_hit = raw & en_q & ~route_q;
        fiq_hit = raw & en_q & route_q;
    end

endmodule

// File: rtl/intr_read_mux.sv
// Registered read port.
// Selects the addressed view on an accepted read; a refused read or an
// unmapped offset yields zero. The output holds between reads.
module intr_read_mux
    import intr_route_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic               rd_ok,
    input  reg_sel_e           rd_sel,
    input  logic [NUM_SRC-1:0] irq_vec,
    input  logic [NUM_SRC-1:0] fiq_vec,
    input  logic [NUM_SRC-1:0] raw_vec,
    input  logic [NUM_SRC-1:0] route_vec,
    input  logic [NUM_SRC-1:0] en_vec,
    input  logic [NUM_SRC-1:0] sw_vec,
    input  logic               guard_q,
    output logic [DATA_W-1:0]  rdata
);

    logic [DATA_W-1:0] pick;

    // Choose the view that the selector names.
    always_comb begin
        case (rd_sel)
            SEL_IRQ_VIEW: pick = DATA_W'(irq_vec);
            SEL_FIQ_VIEW: pick = DATA_W'(fiq_vec);
            SEL_RAW_VIEW: pick = DATA_W'(raw_vec);
            SEL_ROUTE:    pick = DATA_W'(route_vec);
            SEL_EN_SET:   pick = DATA_W'(en_vec);
            SEL_SW_SET:   pick = DATA_W'(sw_vec);
            SEL_GUARD:    pick = DATA_W'(guard_q);
            default:      pick = '0;
        endcase
    end

    // Capture read data on an accepted read; a refused read returns zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_ok ? pick : '0;
        end
    end

endmodule

// File: rtl/intr_route_unit.sv
// Interrupt masking and routing unit (top).
// Merges hardware and software requests per source, masks them with the
// enable bits and steers them to the IRQ or FIQ output. Register access is
// through a single-cycle bus qualified by a privilege input.
// Assumes NUM_SRC <= DATA_W and hw_req already synchronous to clk.
module intr_route_unit
    import intr_route_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hw_req,
    input  logic               bus_wr_en,
    input  logic               bus_rd_en,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_priv,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o,
    output logic               fiq_o
);

    wr_strobe_t         wr_stb;
    logic               rd_ok;
    reg_sel_e           rd_sel;
    logic               guard_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] route_q;
    logic [NUM_SRC-1:0] sw_q;
    logic [NUM_SRC-1:0] raw_vec;
    logic [NUM_SRC-1:0] irq_vec;
    logic [NUM_SRC-1:0] fiq_vec;

    intr_bus_gate #(.ADDR_W(ADDR_W)) i_gate (
        .wr_en   (bus_wr_en),
        .rd_en   (bus_rd_en),
        .addr    (bus_addr),
        .priv    (bus_priv),
        .guard_q (guard_q),
        .wr_stb  (wr_stb),
        .rd_ok   (rd_ok),
        .rd_sel  (rd_sel)
    );

    // Guard bit: only a privileged write to its location changes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            guard_q <= 1'b0;
        end else if (wr_stb.guard) begin
            guard_q <= bus_wdata[0];
        end
    end

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        intr_src_cell i_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .hw_line (hw_req[n]),
            .wbit    (bus_wdata[n]),
            .wr_stb  (wr_stb),
            .en_q    (en_q[n]),
            .route_q (route_q[n]),
            .sw_q    (sw_q[n]),
            .raw     (raw_vec[n]),
            .irq_hit (irq_vec[n]),
            .fiq_hit (fiq_vec[n])
        );
    end

    // Collapse the masked views onto the two processor request lines.
    always_comb begin
        irq_o = |irq_vec;
        fiq_o = |fiq_vec;
    end

    intr_read_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) i_rmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (bus_rd_en),
        .rd_ok     (rd_ok),
        .rd_sel    (rd_sel),
        .irq_vec   (irq_vec),
        .fiq_vec   (fiq_vec),
        .raw_vec   (raw_vec),
        .route_vec (route_q),
        .en_vec    (en_q),
        .sw_vec    (sw_q),
        .guard_q   (guard_q),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/intr_route_checker.sv
// Property checker for the interrupt masking and routing unit.
// Observes ports and the stored control bits; drives nothing.
module intr_route_checker
    import intr_route_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr_en,
    input logic               bus_rd_en,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               bus_priv,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               irq_o,
    input logic               fiq_o,
    input logic               guard_q,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] route_q,
    input logic [NUM_SRC-1:0] sw_q
);

    // R1: the request lines are quiet right after reset.
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_o && !fiq_o));

    // R3: the normal line needs an enabled source routed to it.
    p_irq_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((en_q & ~route_q) != '0));

    // R4: the fast line needs an enabled source routed to it.
    p_fiq_needs_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> ((en_q & route_q) != '0));

    // R6: an accepted enable-clear write leaves no written bit set.
    p_enclr_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'(OFF_EN_CLR) && !(guard_q && !bus_priv))
        |=> ((en_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));

    // R8: an unprivileged write never moves the guard bit.
    p_guard_priv_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && !bus_priv) |=> $stable(guard_q));

    // R9: a blocked write leaves every control bit unchanged.
    p_blocked_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && guard_q && !bus_priv)
        |=> ($stable(en_q) && $stable(route_q) && $stable(sw_q)));

    // R9: a blocked read returns zero.
    p_blocked_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && guard_q && !bus_priv) |=> (bus_rdata == '0));

    // R10: read data holds when no read is accepted.
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> $stable(bus_rdata));

endmodule

bind intr_route_unit intr_route_checker #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_priv  (bus_priv),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .guard_q   (guard_q),
    .en_q      (en_q),
    .route_q   (route_q),
    .sw_q      (sw_q)
);

// File: tb/test_intr_route_unit.sv
// Directed bench for the interrupt masking and routing unit.
module test_intr_route_unit;

    localparam int NSRC = 32;
    localparam int DW   = 32;
    localparam int AW   = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] hw_req = '0;
    logic            bus_wr_en = 1'b0;
    logic            bus_rd_en = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [DW-1:0]   bus_wdata = '0;
    logic            bus_priv = 1'b1;
    logic [DW-1:0]   bus_rdata;
    logic            irq_o;
    logic            fiq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model of the stored bits.
    logic [NSRC-1:0] m_en = '0;
    logic [NSRC-1:0] m_route = '0;
    logic [NSRC-1:0] m_sw = '0;

    intr_route_unit #(.NUM_SRC(NSRC), .DATA_W(DW), .ADDR_W(AW)) i_intr_route_unit (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req),
        .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_priv(bus_priv), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic p);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = p;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic rd(input logic [7:0] a, input logic p, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a; bus_priv = p;
        @(negedge clk);
        bus_rd_en = 1'b0; bus_priv = 1'b1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] exp_raw();
        return hw_req | m_sw;
    endfunction
    function automatic logic [31:0] exp_irq();
        return exp_raw() & m_en & ~m_route;
    endfunction
    function automatic logic [31:0] exp_fiq();
        return exp_raw() & m_en & m_route;
    endfunction

    // Compare all three views and both request lines with the model.
    task automatic check_views(input string tag);
        logic [31:0] d;
        rd(8'h08, 1'b1, d); check({tag, " raw R2"}, d, exp_raw());
        rd(8'h00, 1'b1, d); check({tag, " irq view R3"}, d, exp_irq());
        rd(8'h04, 1'b1, d); check({tag, " fiq view R4"}, d, exp_fiq());
        check({tag, " irq_o R3"}, 32'(irq_o), 32'(|exp_irq()));
        check({tag, " fiq_o R4"}, 32'(fiq_o), 32'(|exp_fiq()));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("reset irq_o R1", 32'(irq_o), 0);
        check("reset fiq_o R1", 32'(fiq_o), 0);
        for (int k = 0; k <= 8; k++) begin
            rd(8'(k * 4), 1'b1, d);
            check($sformatf("reset reg %0h R1", k * 4), d, 0);
        end
    endtask

    task automatic t_raw_masked();
        hw_req = 32'hA5A5_0F0F;
        check_views("masked");
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(8'h10, 32'h0000_0F00, 1'b1); m_en = 32'h0000_0F00;
        rd(8'h10, 1'b1, d); check("en set R6", d, m_en);
        wr(8'h10, 32'h8000_0001, 1'b1); m_en |= 32'h8000_0001;
        rd(8'h10, 1'b1, d); check("en set accumulate R6", d, m_en);
        check_views("enabled");
        wr(8'h14, 32'h0000_0301, 1'b1); m_en &= ~32'h0000_0301;
        rd(8'h10, 1'b1, d); check("en clear R6", d, m_en);
        check_views("after clear");
    endtask

    task automatic t_route();
        logic [31:0] d;
        wr(8'h10, 32'hFFFF_FFFF, 1'b1); m_en = '1;
        wr(8'h0C, 32'hF0F0_0000, 1'b1); m_route = 32'hF0F0_0000;
        rd(8'h0C, 1'b1, d); check("route readback R5", d, m_route);
        check_views("split route");
        wr(8'h0C, 32'hFFFF_FFFF, 1'b1); m_route = '1;
        check_views("all fast R5");
        wr(8'h0C, 32'h0000_0000, 1'b1); m_route = '0;
        check_views("all normal R5");
    endtask

    task automatic t_soft();
        logic [31:0] d;
        hw_req = '0;
        wr(8'h14, 32'hFFFF_FFFF, 1'b1); m_en = '0;
        check("idle irq_o R3", 32'(irq_o), 0);
        wr(8'h18, 32'h0001_0040, 1'b1); m_sw = 32'h0001_0040;
        rd(8'h18, 1'b1, d); check("sw set R7", d, m_sw);
        check_views("soft masked");
        wr(8'h10, 32'h0000_0040, 1'b1); m_en = 32'h0000_0040;
        check_views("soft enabled R7");
        wr(8'h1C, 32'h0000_0040, 1'b1); m_sw = 32'h0001_0000;
        rd(8'h18, 1'b1, d); check("sw clear R7", d, m_sw);
        check_views("soft cleared R7");
    endtask

    // Software clear lands while the hardware line of the same source is high.
    task automatic t_clear_vs_hw();
        hw_req = 32'h0000_0040;
        wr(8'h18, 32'h0000_0040, 1'b1); m_sw |= 32'h0000_0040;
        wr(8'h1C, 32'h0000_0040, 1'b1); m_sw &= ~32'h0000_0040;
        check_views("clear under hw R7");
        check("hw keeps irq_o R2", 32'(irq_o), 1);
        hw_req = '0;
    endtask

    task automatic t_guard();
        logic [31:0] d;
        wr(8'h20, 32'h0000_0001, 1'b0);
        rd(8'h20, 1'b1, d); check("user guard write R8", d, 0);
        wr(8'h20, 32'hFFFF_FFFF, 1'b1);
        rd(8'h20, 1'b1, d); check("priv guard write R8", d, 1);
        wr(8'h10, 32'hFFFF_0000, 1'b0);
        wr(8'h0C, 32'hFFFF_FFFF, 1'b0);
        wr(8'h18, 32'h0F00_0000, 1'b0);
        wr(8'h20, 32'h0000_0000, 1'b0);
        rd(8'h10, 1'b1, d); check("blocked en write R9", d, m_en);
        rd(8'h0C, 1'b1, d); check("blocked route write R9", d, m_route);
        rd(8'h18, 1'b1, d); check("blocked sw write R9", d, m_sw);
        rd(8'h20, 1'b1, d); check("blocked guard write R8", d, 1);
        rd(8'h18, 1'b0, d); check("blocked read R9", d, 0);
        wr(8'h20, 32'h0000_0000, 1'b1);
        rd(8'h18, 1'b0, d); check("user read open R9", d, m_sw);
    endtask

    // Write and read the same register on one edge.
    task automatic t_same_edge();
        logic [31:0] d;
        logic [31:0] old_en;
        old_en = m_en;
        @(negedge clk);
        bus_wr_en = 1'b1; bus_rd_en = 1'b1; bus_addr = 8'h10;
        bus_wdata = 32'h00F0_0000; bus_priv = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_rd_en = 1'b0;
        m_en |= 32'h00F0_0000;
        check("same edge old value R10", bus_rdata, old_en);
        repeat (2) @(negedge clk);
        check("rdata holds R10", bus_rdata, old_en);
        rd(8'h10, 1'b1, d); check("same edge new value R10", d, m_en);
        rd(8'h24, 1'b1, d); check("unmapped read R10", d, 0);
        wr(8'h00, 32'hFFFF_FFFF, 1'b1);
        wr(8'h08, 32'hFFFF_FFFF, 1'b1);
        rd(8'h10, 1'b1, d); check("ro write en R10", d, m_en);
        rd(8'h0C, 1'b1, d); check("ro write route R10", d, m_route);
        rd(8'h18, 1'b1, d); check("ro write sw R10", d, m_sw);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_raw_masked();
        t_enable();
        t_route();
        t_soft();
        t_clear_vs_hw();
        t_guard();
        t_same_edge();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule